// File: doc/BRIEF.md
# Three-Phase Hall Commutator with Pulse-by-Pulse Chop Gating

This block turns three rotor-position sensor signals, spaced 120 electrical degrees apart, into six switch commands for a three-phase inverter bridge. There are three high-side commands and three low-side commands. A direction input selects which phase pair each sensor state energises. A mode input picks how the PWM chop is applied: either to the low-side switch only, or to both switches of the active pair. Coast, brake and undervoltage inputs override the normal decode, each with a fixed precedence.

The PWM comparator result and the overcurrent trip come from analog circuitry outside the block. They arrive as synchronous digital levels. Each one feeds a latch that the carrier's cycle-start pulse clears. Once the switches are turned off inside a carrier period, they stay off until the next period begins. The sensor inputs pass through a synchroniser before they are decoded.

Top module: `bldc_commutator`

## Requirements
- R1: While reset is asserted, every high-side and low-side command is 0.
- R2: Sensor bits are ordered {A,B,C} = hall_i[2:0]. Gate vectors are also {A,B,C} = bit 2, bit 1, bit 0. With dir_fwd_i=1, the codes map as follows (high/low phase):
  - 101 to A/B
  - 100 to A/C
  - 110 to B/C
  - 010 to B/A
  - 011 to C/A
  - 001 to C/B
- R3: With dir_fwd_i=0, each valid code drives the same two phases as in R2, with the high-side and low-side roles swapped.
- R4: Sensor codes 000 and 111 drive all six commands to 0.
- R5: coast_i=1 forces all six commands to 0, whatever the other inputs are.
- R6: uvlo_i=1 forces all six commands to 0, whatever the other inputs are.
- R7: With brake_i=1, and coast_i and uvlo_i both 0, all high-side commands are 0. All low-side commands are 1 unless the chop is blanking, in which case they are 0.
- R8: With quad_i=0, blanking clears only the active low-side command. The active high-side command stays on.
- R9: With quad_i=1, blanking clears both the active high-side command and the active low-side command.
- R10: pwm_on_i=0 blanks the commands in the same cycle. Blanking then persists, even after pwm_on_i returns to 1, until a cycle where cyc_start_i=1. That cycle releases the blanking in the same cycle.
- R11: A one-cycle oc_trip_i pulse blanks the commands and holds them blanked until cyc_start_i=1, in the same way as R10.
- R12: A change on hall_i first reaches the commands after SYNC_STAGES rising clock edges, which is 2 by default, and not earlier.
- R13: At most one high-side command and at most one low-side command are active at any time, except during brake. A high-side and a low-side command of the same phase are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Rotor sensor levels {A,B,C}, asynchronous |
| dir_fwd_i | input | 1 | 1 = forward sequence, 0 = reversed roles |
| quad_i | input | 1 | 0 = chop low side only, 1 = chop both sides |
| brake_i | input | 1 | Brake request |
| coast_i | input | 1 | Coast request, all switches off |
| uvlo_i | input | 1 | Supply undervoltage flag |
| pwm_on_i | input | 1 | PWM comparator result, 1 = conduct |
| oc_trip_i | input | 1 | Overcurrent comparator trip |
| cyc_start_i | input | 1 | Carrier cycle-start pulse, clears the chop latches |
| gate_hi_o | output | 3 | High-side commands {A,B,C} |
| gate_lo_o | output | 3 | Low-side commands {A,B,C} |

## Verification
The bench sweeps all eight sensor codes against both directions, both chop modes, and four override settings (none, brake, coast, undervoltage). This separates the forward table from the swapped reverse table, and valid codes from the two illegal ones. It also shows that each override takes precedence over the decode.

For every combination, the bench samples the commands in three situations:
- with the PWM input high;
- right after the PWM input drops;
- after the PWM input rises again with no cycle start.

It then samples once more on the cycle-start pulse. This tells low-side-only chopping apart from both-side chopping, and a latched off-state apart from a transparent one.

Separate sequences cover the overcurrent latch and the exact synchroniser latency.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
   localparam int unsigned PHASES = 3;
   typedef logic [PHASES-1:0] phase_vec_t;
   localparam phase_vec_t PH_A = 3'b100;
   localparam phase_vec_t PH_B = 3'b010;
   localparam phase_vec_t PH_C = 3'b001;
endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[g] <= '0;
               else        stage_q[g] <= async_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[g] <= '0;
               else        stage_q[g] <= stage_q[g-1];
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/chop_latch.sv
module chop_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic blank_o
);
   logic held_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     held_q <= 1'b0;
      else if (clr_i) held_q <= 1'b0;
      else            held_q <= held_q | set_i;

   assign blank_o = (held_q & ~clr_i) | set_i;

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> (blank_o || clr_i)); // R10, R11
   AST_LATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |-> !blank_o); // R10
endmodule

// File: rtl/comm_decode.sv
module comm_decode
   import bldc_pkg::*;
(
   input  logic [2:0]  code_i,
   input  logic        dir_fwd_i,
   output logic        valid_o,
   output phase_vec_t  hi_o,
   output phase_vec_t  lo_o
);
   phase_vec_t fwd_hi, fwd_lo;

   always_comb begin
      valid_o = 1'b1;
      fwd_hi  = '0;
      fwd_lo  = '0;
      case (code_i)
         3'b101: begin fwd_hi = PH_A; fwd_lo = PH_B; end
         3'b100: begin fwd_hi = PH_A; fwd_lo = PH_C; end
         3'b110: begin fwd_hi = PH_B; fwd_lo = PH_C; end
         3'b010: begin fwd_hi = PH_B; fwd_lo = PH_A; end
         3'b011: begin fwd_hi = PH_C; fwd_lo = PH_A; end
         3'b001: begin fwd_hi = PH_C; fwd_lo = PH_B; end
         default: valid_o = 1'b0;
      endcase
   end

   assign hi_o = dir_fwd_i ? fwd_hi : fwd_lo;
   assign lo_o = dir_fwd_i ? fwd_lo : fwd_hi;
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_i,
   input  logic       dir_fwd_i,
   input  logic       quad_i,
   input  logic       brake_i,
   input  logic       coast_i,
   input  logic       uvlo_i,
   input  logic       pwm_on_i,
   input  logic       oc_trip_i,
   input  logic       cyc_start_i,
   output logic [2:0] gate_hi_o,
   output logic [2:0] gate_lo_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0]  hall_s;
   logic        code_ok;
   phase_vec_t  dec_hi, dec_lo;
   logic        pwm_blank, oc_blank, blank;
   logic        force_off;

   hall_sync #(.WIDTH(PHASES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(hall_i), .sync_o(hall_s));

   comm_decode u_dec (
      .code_i(hall_s), .dir_fwd_i(dir_fwd_i),
      .valid_o(code_ok), .hi_o(dec_hi), .lo_o(dec_lo));

   chop_latch u_pwm_latch (
      .clk(clk), .rst_n(rst_n), .set_i(~pwm_on_i), .clr_i(cyc_start_i),
      .blank_o(pwm_blank));

   chop_latch u_oc_latch (
      .clk(clk), .rst_n(rst_n), .set_i(oc_trip_i), .clr_i(cyc_start_i),
      .blank_o(oc_blank));

   assign blank     = pwm_blank | oc_blank;
   assign force_off = coast_i | uvlo_i | ~rst_n;

   always_comb begin
      if (force_off) begin
         gate_hi_o = '0;
         gate_lo_o = '0;
      end else if (brake_i) begin
         gate_hi_o = '0;
         gate_lo_o = {PHASES{~blank}};
      end else if (!code_ok) begin
         gate_hi_o = '0;
         gate_lo_o = '0;
      end else begin
         gate_hi_o = (quad_i && blank) ? '0 : dec_hi;
         gate_lo_o = blank ? '0 : dec_lo;
      end
   end

   AST_COAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      coast_i |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000)); // R5
   AST_UVLO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_i |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000)); // R6
   AST_BRAKE_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      brake_i |-> (gate_hi_o == 3'b000)); // R7
   AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi_o & gate_lo_o) == 3'b000); // R13
   AST_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      !brake_i |-> ($onehot0(gate_hi_o) && $onehot0(gate_lo_o))); // R13
   AST_LOW_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_on_i || oc_trip_i) |-> (gate_lo_o == 3'b000)); // R10
   AST_OC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(oc_trip_i) && !cyc_start_i && !$past(cyc_start_i)) |-> (gate_lo_o == 3'b000)); // R11
endmodule

// File: tb/bldc_commutator_bench.sv
module bldc_commutator_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] hall = 3'b101;
   logic dir = 1'b1, quad = 1'b0, brake = 1'b0, coast = 1'b0, uv = 1'b0;
   logic pwm_on = 1'b1, oc = 1'b0, cyc = 1'b0;
   logic [2:0] ghi, glo;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   bldc_commutator u_bldc_commutator (
      .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_fwd_i(dir), .quad_i(quad),
      .brake_i(brake), .coast_i(coast), .uvlo_i(uv), .pwm_on_i(pwm_on),
      .oc_trip_i(oc), .cyc_start_i(cyc), .gate_hi_o(ghi), .gate_lo_o(glo));

   // Expected {hi,lo}, built from phase arithmetic: step s, high phase s/2,
   // low phase (high+1+s%2)%3, roles swapped in reverse. Phase p -> bit 2-p.
   function automatic logic [5:0] model(input logic [2:0] c, input logic d,
         input logic q, input logic bk, input logic cs, input logic u, input logic bl);
      int s, hp, lp;
      logic [2:0] h, l;
      if (cs || u) return 6'b0;
      if (bk) return {3'b000, bl ? 3'b000 : 3'b111};
      case (c)
         3'b101: s = 0; 3'b100: s = 1; 3'b110: s = 2;
         3'b010: s = 3; 3'b011: s = 4; 3'b001: s = 5;
         default: s = -1;
      endcase
      if (s < 0) return 6'b0;
      hp = s / 2;
      lp = (hp + 1 + (s % 2)) % 3;
      h = 3'b100 >> (d ? hp : lp);
      l = 3'b100 >> (d ? lp : hp);
      if (bl) begin
         l = 3'b000;
         if (q) h = 3'b000;
      end
      return {h, l};
   endfunction

   task automatic chk(input string tag, input logic [5:0] exp);
      checks++;
      if ({ghi, glo} !== exp) begin
         errors++;
         $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, ghi, glo, exp[5:3], exp[2:0]);
      end
   endtask

   function automatic string tag_for(input logic [2:0] c, input logic d, input int m);
      if (m == 1) return "R7";
      if (m == 2) return "R5";
      if (m == 3) return "R6";
      if (c == 3'b000 || c == 3'b111) return "R4";
      return d ? "R2" : "R3";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: outputs off during reset even with a valid code and PWM on
      repeat (3) @(negedge clk);
      chk("R1", 6'b0);
      rst_n = 1'b1;

      // Full sweep
      for (int c = 0; c < 8; c++)
         for (int d = 0; d < 2; d++)
            for (int q = 0; q < 2; q++)
               for (int m = 0; m < 4; m++) begin
                  string t;
                  string tb;
                  @(negedge clk);
                  hall = c[2:0]; dir = d[0]; quad = q[0];
                  brake = (m == 1); coast = (m == 2); uv = (m == 3);
                  pwm_on = 1'b1; oc = 1'b0; cyc = 1'b1;
                  @(negedge clk); cyc = 1'b0;
                  @(negedge clk); #1;
                  t = tag_for(c[2:0], d[0], m);
                  chk(t, model(c[2:0], d[0], q[0], brake, coast, uv, 1'b0));
                  checks++;
                  if ((ghi & glo) != 3'b000) begin
                     errors++;
                     $display("FAIL R13: hi=%b lo=%b expected disjoint", ghi, glo);
                  end
                  tb = (m == 1) ? "R7" : (q ? "R9" : "R8");
                  pwm_on = 1'b0; #1;
                  chk(tb, model(c[2:0], d[0], q[0], brake, coast, uv, 1'b1));
                  @(negedge clk); pwm_on = 1'b1; #1;
                  chk("R10", model(c[2:0], d[0], q[0], brake, coast, uv, 1'b1));
                  cyc = 1'b1; #1;
                  chk("R10", model(c[2:0], d[0], q[0], brake, coast, uv, 1'b0));
                  @(negedge clk); cyc = 1'b0;
               end

      // R11: overcurrent pulse held until cycle start
      @(negedge clk);
      hall = 3'b110; dir = 1'b1; quad = 1'b1; brake = 1'b0; coast = 1'b0; uv = 1'b0;
      @(negedge clk); @(negedge clk); #1;
      chk("R11", model(3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
      oc = 1'b1; #1;
      chk("R11", 6'b0);
      @(negedge clk); oc = 1'b0;
      repeat (3) @(negedge clk); #1;
      chk("R11", 6'b0);
      cyc = 1'b1; #1;
      chk("R11", model(3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
      @(negedge clk); cyc = 1'b0;

      // R12: exact synchroniser latency
      quad = 1'b0;
      @(negedge clk); hall = 3'b011;
      @(negedge clk); #1;
      chk("R12", model(3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      @(negedge clk); #1;
      chk("R12", model(3'b011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule